// File: doc/BRIEF.md
# Dual-Ratio Performance Mode Sequencer

This block sits on the platform side of a processor and moves it between two core-frequency modes: a low-frequency mode that saves power and a high-frequency mode for maximum performance. The move needs no processor reset, and the bus clock is left alone. Only two core-to-bus ratios exist, and a single active-low ratio-select output picks between them. Asserting the select (driving it low) chooses the high ratio.

A controller asks for a mode change by pulsing `req_valid` with the wanted mode on `req_target`. The sequencer makes every frequency change inside a deep-sleep window. It raises `sleep_req` and waits for the clock-state controller to acknowledge on `sleep_ack`. Going up, it raises the core voltage first and waits for `vgood`, then asserts the ratio select. Going down, it deasserts the ratio select first and then lowers the voltage, waiting for `vgood`. It then releases deep sleep and keeps `busy` high until the deep-sleep exit latency (30 us by default) has run out.

States:
- ST_IDLE (not busy).
- ST_SLEEP_WAIT (deep sleep requested, waiting for acknowledge).
- ST_VOLT_UP (voltage raise requested, waiting for good).
- ST_RATIO_LOW (ratio select just asserted).
- ST_RATIO_HIGH (ratio select just deasserted).
- ST_VOLT_DOWN (voltage lowered, waiting for good).
- ST_EXIT_HOLD (deep sleep released, exit latency running).

Transitions:
- accept: ST_IDLE to ST_SLEEP_WAIT.
- ack_up: ST_SLEEP_WAIT to ST_VOLT_UP.
- ack_down: ST_SLEEP_WAIT to ST_RATIO_HIGH.
- volt_ok_up: ST_VOLT_UP to ST_RATIO_LOW.
- ratio_done_up: ST_RATIO_LOW to ST_EXIT_HOLD.
- ratio_done_down: ST_RATIO_HIGH to ST_VOLT_DOWN.
- volt_ok_down: ST_VOLT_DOWN to ST_EXIT_HOLD.
- latency_done: ST_EXIT_HOLD to ST_IDLE.

Top module: `perf_mode_seq`

## Requirements
- R1: While reset is asserted and right after it, `ratio_sel_n`=1, `vraise_req`=0, `sleep_req`=0, `busy`=0 and `mode_high`=0, which is the low-frequency mode.
- R2: In ST_IDLE, a `req_valid` whose `req_target` (1 = high mode, 0 = low mode) differs from `mode_high` is accepted. From the next cycle `busy`=1 and `sleep_req`=1.
- R3: Neither `vraise_req` nor `ratio_sel_n` changes before `sleep_ack` has been sampled high during the deep-sleep request.
- R4: Going up, `vraise_req` rises on the edge that samples `sleep_ack`. `ratio_sel_n` falls only on an edge that samples `vgood` high at least one cycle after that. `sleep_req` falls on the following edge.
- R5: Going down, `ratio_sel_n` rises on the edge that samples `sleep_ack`. `vraise_req` falls on the next edge. `sleep_req` falls only on an edge that samples `vgood` high at least one cycle after `vraise_req` fell.
- R6: After `sleep_req` falls, `busy` stays high for exactly EXIT_US*CLK_MHZ cycles and then goes low.
- R7: A request whose `req_target` equals `mode_high` is ignored. No output changes.
- R8: Requests that arrive while `busy`=1 are ignored. The running transition ends in its original target mode.
- R9: `mode_high` always equals the inverse of `ratio_sel_n`, and `ratio_sel_n` and `vraise_req` change only while `sleep_req`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Mode-change request strobe |
| req_target | input | 1 | Requested mode, 1 = high frequency |
| sleep_ack | input | 1 | Clock-state controller reports deep sleep entered |
| vgood | input | 1 | Regulator output settled at the requested level |
| sleep_req | output | 1 | Deep-sleep request to the clock-state controller |
| vraise_req | output | 1 | 1 = high core voltage requested |
| ratio_sel_n | output | 1 | Active-low ratio select, 0 = high ratio |
| mode_high | output | 1 | Current mode, 1 = high frequency |
| busy | output | 1 | Transition in progress |

## Verification
The bench builds the sequencer with CLK_MHZ=1 and EXIT_US=4, which gives an exit hold of four cycles. The whole latency window can then be checked cycle by cycle on every transition. With that short window, a sweep covers both directions, every acknowledge delay from 0 to 3 cycles and every voltage-settle delay from 0 to 3 cycles. The sweep also checks that outputs stay frozen during each wait and that stray requests during a transition are ignored.

// File: rtl/perf_mode_pkg.sv
package perf_mode_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SLEEP_WAIT,
        ST_VOLT_UP,
        ST_RATIO_LOW,
        ST_RATIO_HIGH,
        ST_VOLT_DOWN,
        ST_EXIT_HOLD
    } seq_state_t;

endpackage

// File: rtl/perf_exit_timer.sv
module perf_exit_timer #(
    parameter int unsigned HOLD_CYCLES = 3000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic expired
);
    localparam int unsigned CW = $clog2(HOLD_CYCLES + 1);
    localparam logic [CW-1:0] LOAD_VAL = CW'(HOLD_CYCLES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= LOAD_VAL;
        end else if (run && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);

    // R6: a freshly loaded count is never already expired unless the hold is one cycle
    a_r6_load_not_expired: assert property (@(posedge clk) disable iff (!rst_n)
        (load && HOLD_CYCLES > 1) |=> !expired);

endmodule

// File: rtl/perf_mode_fsm.sv
module perf_mode_fsm
    import perf_mode_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic req_target,
    input  logic sleep_ack,
    input  logic vgood,
    input  logic hold_expired,
    output logic hold_load,
    output logic hold_run,
    output logic sleep_req,
    output logic vraise_req,
    output logic ratio_sel_n,
    output logic busy
);
    seq_state_t state, state_nx;
    logic       going_up;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            going_up <= 1'b0;
        end else begin
            state <= state_nx;
            if (state == ST_IDLE && state_nx == ST_SLEEP_WAIT) begin
                going_up <= req_target;
            end
        end
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:       if (req_valid && (req_target == ratio_sel_n)) state_nx = ST_SLEEP_WAIT;
            ST_SLEEP_WAIT: if (sleep_ack) state_nx = going_up ? ST_VOLT_UP : ST_RATIO_HIGH;
            ST_VOLT_UP:    if (vgood) state_nx = ST_RATIO_LOW;
            ST_RATIO_LOW:  state_nx = ST_EXIT_HOLD;
            ST_RATIO_HIGH: state_nx = ST_VOLT_DOWN;
            ST_VOLT_DOWN:  if (vgood) state_nx = ST_EXIT_HOLD;
            ST_EXIT_HOLD:  if (hold_expired) state_nx = ST_IDLE;
            default:       state_nx = ST_IDLE;
        endcase
    end

    // registered control outputs: voltage request and ratio select
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vraise_req  <= 1'b0;
            ratio_sel_n <= 1'b1;
        end else begin
            if (state == ST_SLEEP_WAIT && state_nx == ST_VOLT_UP)    vraise_req  <= 1'b1;
            if (state == ST_RATIO_HIGH)                              vraise_req  <= 1'b0;
            if (state == ST_VOLT_UP && state_nx == ST_RATIO_LOW)     ratio_sel_n <= 1'b0;
            if (state == ST_SLEEP_WAIT && state_nx == ST_RATIO_HIGH) ratio_sel_n <= 1'b1;
        end
    end

    // decoded outputs
    always_comb begin
        sleep_req = 1'b0;
        busy      = (state != ST_IDLE);
        hold_run  = (state == ST_EXIT_HOLD);
        hold_load = (state_nx == ST_EXIT_HOLD) && (state != ST_EXIT_HOLD);
        unique case (state)
            ST_SLEEP_WAIT, ST_VOLT_UP, ST_RATIO_LOW,
            ST_RATIO_HIGH, ST_VOLT_DOWN: sleep_req = 1'b1;
            default:                     sleep_req = 1'b0;
        endcase
    end

    // R3: voltage request only rises after deep sleep was acknowledged
    a_r3_raise_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vraise_req) |-> $past(sleep_ack));

    // R4: high ratio only selected while the voltage is raised
    a_r4_ratio_after_volt: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ratio_sel_n) |-> vraise_req);

    // R5: voltage only lowered after the low ratio is back
    a_r5_volt_after_ratio: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vraise_req) |-> ratio_sel_n);

    // R9: ratio and voltage move only inside the deep-sleep window
    a_r9_change_in_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(ratio_sel_n) || !$stable(vraise_req)) |-> $past(sleep_req));

    // R7: same-mode request while idle leaves the block idle
    a_r7_same_mode_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid && (req_target != ratio_sel_n)) |=> !busy);

endmodule

// File: rtl/perf_mode_seq.sv
module perf_mode_seq #(
    parameter int unsigned CLK_MHZ = 100,
    parameter int unsigned EXIT_US = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic req_target,
    input  logic sleep_ack,
    input  logic vgood,
    output logic sleep_req,
    output logic vraise_req,
    output logic ratio_sel_n,
    output logic mode_high,
    output logic busy
);
    localparam int unsigned HOLD_CYCLES = (CLK_MHZ * EXIT_US < 1) ? 1 : CLK_MHZ * EXIT_US;

    logic hold_load, hold_run, hold_expired;

    perf_mode_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_target   (req_target),
        .sleep_ack    (sleep_ack),
        .vgood        (vgood),
        .hold_expired (hold_expired),
        .hold_load    (hold_load),
        .hold_run     (hold_run),
        .sleep_req    (sleep_req),
        .vraise_req   (vraise_req),
        .ratio_sel_n  (ratio_sel_n),
        .busy         (busy)
    );

    perf_exit_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (hold_load),
        .run     (hold_run),
        .expired (hold_expired)
    );

    assign mode_high = ~ratio_sel_n;

endmodule

// File: tb/test_perf_mode_seq.sv
module test_perf_mode_seq;
    localparam int unsigned CLK_MHZ = 1;
    localparam int unsigned EXIT_US = 4;
    localparam int          HOLD    = CLK_MHZ * EXIT_US;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_target = 1'b0, sleep_ack = 1'b0, vgood = 1'b1;
    logic sleep_req, vraise_req, ratio_sel_n, mode_high, busy;

    int total = 0;
    int bad   = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    perf_mode_seq #(.CLK_MHZ(CLK_MHZ), .EXIT_US(EXIT_US)) i_perf_mode_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_target(req_target),
        .sleep_ack(sleep_ack), .vgood(vgood), .sleep_req(sleep_req),
        .vraise_req(vraise_req), .ratio_sel_n(ratio_sel_n),
        .mode_high(mode_high), .busy(busy)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0b expected=%0b t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic step;
        @(negedge clk);
    endtask

    task automatic check_mode(input string tag, input logic high);
        chk({tag, " R9 mode_high"}, mode_high, high);
        chk({tag, " R9 ratio_sel_n"}, ratio_sel_n, ~high);
        chk({tag, " R9 vraise_req"}, vraise_req, high);
    endtask

    task automatic same_mode(input logic cur);
        req_valid = 1'b1; req_target = cur;
        step;
        req_valid = 1'b0;
        chk("R7 busy", busy, 1'b0);
        chk("R7 sleep_req", sleep_req, 1'b0);
        check_mode("R7", cur);
        step;
        chk("R7 busy later", busy, 1'b0);
    endtask

    task automatic transition(input logic tgt, input int ad, input int vd);
        req_valid = 1'b1; req_target = tgt;
        step;
        req_valid = 1'b0;
        chk("R2 busy", busy, 1'b1);
        chk("R2 sleep_req", sleep_req, 1'b1);
        for (int i = 0; i < ad; i++) begin
            req_valid = 1'b1; req_target = ~tgt;
            step;
            req_valid = 1'b0;
            chk("R3 vraise frozen", vraise_req, ~tgt);
            chk("R3 ratio frozen", ratio_sel_n, tgt);
            chk("R8 busy held", busy, 1'b1);
        end
        sleep_ack = 1'b1; req_valid = 1'b1; req_target = ~tgt;
        step;
        req_valid = 1'b0;
        if (tgt) begin
            chk("R4 vraise up", vraise_req, 1'b1);
            chk("R4 ratio still low", ratio_sel_n, 1'b1);
            vgood = 1'b0;
            for (int i = 0; i < vd; i++) begin
                step;
                chk("R4 ratio waits vgood", ratio_sel_n, 1'b1);
            end
            vgood = 1'b1;
            step;
            chk("R4 ratio asserted", ratio_sel_n, 1'b0);
            chk("R4 sleep held", sleep_req, 1'b1);
            chk("R9 mode up", mode_high, 1'b1);
            step;
        end else begin
            chk("R5 ratio released", ratio_sel_n, 1'b1);
            chk("R5 vraise still up", vraise_req, 1'b1);
            step;
            chk("R5 vraise down", vraise_req, 1'b0);
            chk("R5 sleep held", sleep_req, 1'b1);
            vgood = 1'b0;
            for (int i = 0; i < vd; i++) begin
                step;
                chk("R5 sleep waits vgood", sleep_req, 1'b1);
            end
            vgood = 1'b1;
            step;
        end
        sleep_ack = 1'b0;
        chk(tgt ? "R4 sleep released" : "R5 sleep released", sleep_req, 1'b0);
        chk("R6 busy at exit", busy, 1'b1);
        for (int k = 1; k < HOLD; k++) begin
            req_valid = 1'b1; req_target = ~tgt;
            step;
            req_valid = 1'b0;
            chk("R6 busy holding", busy, 1'b1);
        end
        step;
        chk("R6 busy cleared", busy, 1'b0);
        check_mode("R8 final", tgt);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                bad++; total++;
                $display("FAIL watchdog actual=%0d expected<=100000", cycles);
                $display("  test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        step;
        chk("R1 reset busy", busy, 1'b0);
        chk("R1 reset sleep", sleep_req, 1'b0);
        check_mode("R1 reset", 1'b0);
        step;
        rst_n = 1'b1;
        step;
        chk("R1 after reset busy", busy, 1'b0);
        check_mode("R1 after reset", 1'b0);
        same_mode(1'b0);
        for (int a = 0; a < 4; a++) begin
            for (int v = 0; v < 4; v++) begin
                transition(1'b1, a, v);
                same_mode(1'b1);
                transition(1'b0, v, a);
                same_mode(1'b0);
            end
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule